// File: doc/BRIEF.md
# Show-Cycle External Bus Control

This block decides what the external bus pins do while the processor runs an access on its internal bus. Every access carries an address, a function code, a transfer size and a read/write flag. Those four always appear on the external outputs, so an analyzer watching the pins can follow the internal traffic. What else appears depends on a 2-bit show mode held in a small configuration register.

With the show mode off, an internal access leaves the address strobe and data strobe unasserted, and the data bus stays released. With the show mode on, the data strobe marks the internal access and the internal data is driven onto the data bus. The address strobe still stays unasserted, so external memory never answers a shown cycle. One encoding also asks the internal bus to halt while an external master owns the bus. In the other encodings, internal work continues during that time.

Accesses that target external space assert both strobes, and a write also drives the data bus. While an external master owns the bus, every strobe and data-bus enable is held off in every mode, so the data bus never has two drivers. All pin outputs are registered and follow their inputs by one clock.

Top module: `show_cycle_ctl`

## Requirements
- R1: After reset, the show mode reads 00, and the strobe enables, the data-bus enable, the halt request and the driven data are all 0.
- R2: When `cfg_we` is high at a clock edge, the show mode takes `cfg_wdata` and appears on `cfg_mode` one clock later. When `cfg_we` is low, the mode holds its value.
- R3: On any access (`int_strobe`=1), whatever the mode, target or bus owner, `ext_addr`, `ext_fc`, `ext_size` and `ext_rw` show the access's values one clock later. Without a strobe they hold their values.
- R4: With mode 00, an internal access (`int_is_ext`=0) leaves `ds_en` and `dbus_oe` low.
- R5: With mode 01, 10 or 11 and no external owner (`ext_owned`=0), an internal access raises `ds_en` and `dbus_oe` one clock later, and `dbus_out` equals the access's `int_data`. Mode 10 behaves exactly like 01.
- R6: An internal access never raises `as_en`, in any mode.
- R7: When `ext_owned`=1 during a cycle, `as_en`, `ds_en` and `dbus_oe` are low one clock later, whatever the mode and the access.
- R8: One clock after a cycle with mode 11 and `ext_owned`=1, `halt_req` is 1. In every other case it is 0.
- R9: An external-space access (`int_is_ext`=1) with `ext_owned`=0 raises `as_en` and `ds_en` one clock later. `dbus_oe` rises only for a write (`int_rw`=0, where `int_rw`=1 means read), and `dbus_out` then equals `int_data`.
- R10: A cycle without `int_strobe` leaves `as_en`, `ds_en` and `dbus_oe` low one clock later. `dbus_out` holds its last driven value whenever `dbus_oe` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Show-mode write enable |
| cfg_wdata | input | 2 | Show-mode write data |
| cfg_mode | output | 2 | Current show mode |
| int_strobe | input | 1 | Internal bus access strobe |
| int_is_ext | input | 1 | Access targets external space |
| int_addr | input | AW (24) | Internal address |
| int_fc | input | FCW (3) | Internal function code |
| int_size | input | SZW (2) | Internal transfer size |
| int_rw | input | 1 | 1 = read, 0 = write |
| int_data | input | DW (16) | Data on the internal bus |
| ext_owned | input | 1 | An external master owns the bus |
| ext_addr | output | AW | External address outputs |
| ext_fc | output | FCW | External function-code outputs |
| ext_size | output | SZW | External size outputs |
| ext_rw | output | 1 | External read/write output |
| as_en | output | 1 | Address strobe assert enable |
| ds_en | output | 1 | Data strobe assert enable |
| dbus_oe | output | 1 | Data bus output enable |
| dbus_out | output | DW | Data driven on the data bus |
| halt_req | output | 1 | Request to halt internal bus activity |

## Verification
The bench builds the block with its default widths: a 24-bit address, 16-bit data, a 3-bit function code and a 2-bit size. These widths are small enough that every field value can be computed from the sweep index and compared directly. The bench loads each of the four show modes through the write port, including the reserved one. Under each mode it applies all sixteen combinations of strobe, target, read/write and external ownership. This reaches every strobe, enable and halt outcome, and the hold behaviour of the address and data registers between accesses.

// File: rtl/show_pkg.sv
package show_pkg;

    typedef enum logic [1:0] {
        SHOW_OFF      = 2'b00,
        SHOW_ON       = 2'b01,
        SHOW_RSVD     = 2'b10,
        SHOW_ON_HALT  = 2'b11
    } show_mode_t;

    // Any nonzero encoding mirrors internal cycles on the pins.
    function automatic logic mode_shows(input show_mode_t m);
        return m != SHOW_OFF;
    endfunction

    // Only one encoding stalls internal traffic under an external owner.
    function automatic logic mode_halts(input show_mode_t m);
        return m == SHOW_ON_HALT;
    endfunction

endpackage

// File: rtl/show_mode_reg.sv
module show_mode_reg
    import show_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       we,
    input  logic [1:0] wdata,
    output show_mode_t mode
);

    typedef struct packed {
        show_mode_t mode;
    } mode_state_t;

    mode_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (we) begin
            st_d.mode = show_mode_t'(wdata);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{mode: SHOW_OFF};
        end else begin
            st_q <= st_d;
        end
    end

    assign mode = st_q.mode;

    a_r2_mode_load: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> (mode == show_mode_t'($past(wdata))));

    a_r2_mode_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(mode));

endmodule

// File: rtl/show_pin_ctl.sv
module show_pin_ctl
    import show_pkg::*;
#(
    parameter int AW  = 24,
    parameter int DW  = 16,
    parameter int FCW = 3,
    parameter int SZW = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  show_mode_t     mode,
    input  logic           strobe,
    input  logic           is_ext,
    input  logic [AW-1:0]  addr,
    input  logic [FCW-1:0] fc,
    input  logic [SZW-1:0] size,
    input  logic           rw,
    input  logic [DW-1:0]  data,
    input  logic           owned,
    output logic [AW-1:0]  ext_addr,
    output logic [FCW-1:0] ext_fc,
    output logic [SZW-1:0] ext_size,
    output logic           ext_rw,
    output logic           as_en,
    output logic           ds_en,
    output logic           dbus_oe,
    output logic [DW-1:0]  dbus_out,
    output logic           halt_req
);

    typedef struct packed {
        logic [AW-1:0]  addr;
        logic [FCW-1:0] fc;
        logic [SZW-1:0] size;
        logic           rw;
        logic           as_en;
        logic           ds_en;
        logic           oe;
        logic [DW-1:0]  dout;
        logic           halt;
    } pin_state_t;

    pin_state_t st_d, st_q;

    logic int_acc;
    logic ext_acc;
    logic show_now;

    always_comb begin
        int_acc  = strobe && !is_ext;
        ext_acc  = strobe && is_ext && !owned;
        show_now = int_acc && mode_shows(mode) && !owned;

        st_d = st_q;
        if (strobe) begin
            st_d.addr = addr;
            st_d.fc   = fc;
            st_d.size = size;
            st_d.rw   = rw;
        end
        st_d.as_en = ext_acc;
        st_d.ds_en = ext_acc || show_now;
        st_d.oe    = show_now || (ext_acc && !rw);
        if (st_d.oe) begin
            st_d.dout = data;
        end
        st_d.halt = mode_halts(mode) && owned;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ext_addr = st_q.addr;
    assign ext_fc   = st_q.fc;
    assign ext_size = st_q.size;
    assign ext_rw   = st_q.rw;
    assign as_en    = st_q.as_en;
    assign ds_en    = st_q.ds_en;
    assign dbus_oe  = st_q.oe;
    assign dbus_out = st_q.dout;
    assign halt_req = st_q.halt;

    a_r3_addr_follow: assert property (@(posedge clk) disable iff (!rst_n)
        strobe |=> (ext_addr == $past(addr)) && (ext_rw == $past(rw)));

    a_r4_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && !is_ext && mode == SHOW_OFF) |=> (!ds_en && !dbus_oe));

    a_r5_show_drive: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && !is_ext && mode != SHOW_OFF && !owned)
            |=> (ds_en && dbus_oe && dbus_out == $past(data)));

    a_r6_no_as_internal: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && !is_ext) |=> !as_en);

    a_r7_owned_silent: assert property (@(posedge clk) disable iff (!rst_n)
        owned |=> (!as_en && !ds_en && !dbus_oe));

    a_r8_halt_set: assert property (@(posedge clk) disable iff (!rst_n)
        (owned && mode == SHOW_ON_HALT) |=> halt_req);

    a_r8_halt_clear: assert property (@(posedge clk) disable iff (!rst_n)
        !(owned && mode == SHOW_ON_HALT) |=> !halt_req);

    a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !strobe |=> (!as_en && !ds_en && !dbus_oe));

    a_r10_dout_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !dbus_oe |-> $stable(dbus_out) || $rose(dbus_oe) || $fell(dbus_oe));

endmodule

// File: rtl/show_cycle_ctl.sv
module show_cycle_ctl
    import show_pkg::*;
#(
    parameter int AW  = 24,
    parameter int DW  = 16,
    parameter int FCW = 3,
    parameter int SZW = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           cfg_we,
    input  logic [1:0]     cfg_wdata,
    output logic [1:0]     cfg_mode,
    input  logic           int_strobe,
    input  logic           int_is_ext,
    input  logic [AW-1:0]  int_addr,
    input  logic [FCW-1:0] int_fc,
    input  logic [SZW-1:0] int_size,
    input  logic           int_rw,
    input  logic [DW-1:0]  int_data,
    input  logic           ext_owned,
    output logic [AW-1:0]  ext_addr,
    output logic [FCW-1:0] ext_fc,
    output logic [SZW-1:0] ext_size,
    output logic           ext_rw,
    output logic           as_en,
    output logic           ds_en,
    output logic           dbus_oe,
    output logic [DW-1:0]  dbus_out,
    output logic           halt_req
);

    show_mode_t mode;

    show_mode_reg u_mode (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .wdata (cfg_wdata),
        .mode  (mode)
    );

    assign cfg_mode = mode;

    show_pin_ctl #(
        .AW  (AW),
        .DW  (DW),
        .FCW (FCW),
        .SZW (SZW)
    ) u_pins (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode     (mode),
        .strobe   (int_strobe),
        .is_ext   (int_is_ext),
        .addr     (int_addr),
        .fc       (int_fc),
        .size     (int_size),
        .rw       (int_rw),
        .data     (int_data),
        .owned    (ext_owned),
        .ext_addr (ext_addr),
        .ext_fc   (ext_fc),
        .ext_size (ext_size),
        .ext_rw   (ext_rw),
        .as_en    (as_en),
        .ds_en    (ds_en),
        .dbus_oe  (dbus_oe),
        .dbus_out (dbus_out),
        .halt_req (halt_req)
    );

endmodule

// File: tb/show_cycle_ctl_tb.sv
module show_cycle_ctl_tb_top;

    localparam int AW  = 24;
    localparam int DW  = 16;
    localparam int FCW = 3;
    localparam int SZW = 2;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           cfg_we = 1'b0;
    logic [1:0]     cfg_wdata = '0;
    logic [1:0]     cfg_mode;
    logic           int_strobe = 1'b0;
    logic           int_is_ext = 1'b0;
    logic [AW-1:0]  int_addr = '0;
    logic [FCW-1:0] int_fc = '0;
    logic [SZW-1:0] int_size = '0;
    logic           int_rw = 1'b1;
    logic [DW-1:0]  int_data = '0;
    logic           ext_owned = 1'b0;
    logic [AW-1:0]  ext_addr;
    logic [FCW-1:0] ext_fc;
    logic [SZW-1:0] ext_size;
    logic           ext_rw;
    logic           as_en, ds_en, dbus_oe, halt_req;
    logic [DW-1:0]  dbus_out;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    show_cycle_ctl #(.AW(AW), .DW(DW), .FCW(FCW), .SZW(SZW)) dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .cfg_mode(cfg_mode), .int_strobe(int_strobe), .int_is_ext(int_is_ext),
        .int_addr(int_addr), .int_fc(int_fc), .int_size(int_size),
        .int_rw(int_rw), .int_data(int_data), .ext_owned(ext_owned),
        .ext_addr(ext_addr), .ext_fc(ext_fc), .ext_size(ext_size),
        .ext_rw(ext_rw), .as_en(as_en), .ds_en(ds_en), .dbus_oe(dbus_oe),
        .dbus_out(dbus_out), .halt_req(halt_req)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic set_mode(input logic [1:0] m);
        @(negedge clk);
        cfg_we    = 1'b1;
        cfg_wdata = m;
        @(negedge clk);
        cfg_we    = 1'b0;
        cfg_wdata = ~m;
        check("R2", "mode load", 32'(cfg_mode), 32'(m));
        @(negedge clk);
        check("R2", "mode hold", 32'(cfg_mode), 32'(m));
    endtask

    initial begin
        logic [AW-1:0]  e_addr = '0;
        logic [FCW-1:0] e_fc = '0;
        logic [SZW-1:0] e_size = '0;
        logic           e_rw = 1'b0;
        logic [DW-1:0]  e_dout = '0;

        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1", "mode", 32'(cfg_mode), 32'd0);
        check("R1", "as_en", 32'(as_en), 32'd0);
        check("R1", "ds_en", 32'(ds_en), 32'd0);
        check("R1", "dbus_oe", 32'(dbus_oe), 32'd0);
        check("R1", "halt_req", 32'(halt_req), 32'd0);
        check("R1", "dbus_out", 32'(dbus_out), 32'd0);
        rst_n = 1'b1;

        for (int m = 0; m < 4; m++) begin
            set_mode(2'(m));
            for (int c = 0; c < 16; c++) begin
                logic stb, ext, rw, own, shows, eas, eds, eoe, ehalt;
                stb = c[0]; ext = c[1]; rw = c[2]; own = c[3];
                @(negedge clk);
                int_strobe = stb;
                int_is_ext = ext;
                int_rw     = rw;
                ext_owned  = own;
                int_addr   = AW'(32'h0A5000 + m * 97 + c * 13);
                int_fc     = FCW'(c + m);
                int_size   = SZW'(c + 2 * m);
                int_data   = DW'(16'h3C00 + m * 211 + c * 7);

                shows = (m != 0);
                eas   = stb && ext && !own;
                eds   = eas || (stb && !ext && shows && !own);
                eoe   = (stb && !ext && shows && !own) || (eas && !rw);
                ehalt = (m == 3) && own;
                if (stb) begin
                    e_addr = int_addr; e_fc = int_fc; e_size = int_size; e_rw = rw;
                end
                if (eoe) e_dout = int_data;

                @(negedge clk);
                int_strobe = 1'b0;
                ext_owned  = 1'b0;
                check("R3", "ext_addr", 32'(ext_addr), 32'(e_addr));
                check("R3", "ext_fc", 32'(ext_fc), 32'(e_fc));
                check("R3", "ext_size", 32'(ext_size), 32'(e_size));
                check("R3", "ext_rw", 32'(ext_rw), 32'(e_rw));
                if (stb && !ext) check("R6", "as_en internal", 32'(as_en), 32'd0);
                if (stb && !ext && m == 0) begin
                    check("R4", "ds_en off", 32'(ds_en), 32'd0);
                    check("R4", "oe off", 32'(dbus_oe), 32'd0);
                end
                if (stb && !ext && m != 0 && !own) begin
                    check("R5", "ds_en show", 32'(ds_en), 32'd1);
                    check("R5", "oe show", 32'(dbus_oe), 32'd1);
                end
                if (own) begin
                    check("R7", "as_en owned", 32'(as_en), 32'd0);
                    check("R7", "ds_en owned", 32'(ds_en), 32'd0);
                    check("R7", "oe owned", 32'(dbus_oe), 32'd0);
                end
                if (ext && !own && stb) begin
                    check("R9", "as_en ext", 32'(as_en), 32'd1);
                    check("R9", "oe ext", 32'(dbus_oe), 32'(!rw));
                end
                if (!stb) check("R10", "idle ds_en", 32'(ds_en), 32'd0);
                check("R10", "as_en", 32'(as_en), 32'(eas));
                check("R10", "ds_en", 32'(ds_en), 32'(eds));
                check("R10", "dbus_oe", 32'(dbus_oe), 32'(eoe));
                check("R10", "dbus_out", 32'(dbus_out), 32'(e_dout));
                check("R8", "halt_req", 32'(halt_req), 32'(ehalt));
            end
        end
        done = 1'b1;
    end

    initial begin
        for (int i = 0; i < 20000; i++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
        end
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule